// File: doc/BRIEF.md
# Iterative AES-128 Block Encryption Engine

This block encrypts one 128-bit block under a 128-bit key. It follows the AES-128 cipher and computes one full round in each clock cycle. Software, or a neighbouring block, writes the plaintext as four 32-bit words through an addressed write port. Word 0 holds bytes 0 to 3 of the block, which form state column 0. Word 1 holds bytes 4 to 7, and so on. In every word the lowest-numbered byte sits in bits [31:24].

The engine does not hold the key schedule. It drives a round-key index and reads back the 128-bit round key that an external key store presents combinationally for that index. A start pulse is taken only when three things are true: the engine is idle, the key store reports that expansion is complete, and the data-stable flag is set. The cycle in which start is taken performs the initial key addition with key 0. The following ten cycles perform rounds 1 to 10. A one-cycle done pulse then marks the ciphertext as valid. The ciphertext stays readable, word by word through a read address, until the next start is taken.

The write port and the read port have no back-pressure. A write is accepted in every cycle in which the write enable is high. A read returns the addressed word combinationally. Start, busy, done and the key-store flags are plain level or pulse signals.

Top module: `aes128_iter_enc`

## Requirements
- R1: After reset, done and busy are low, the round-key index is 0, and every result word reads 0.
- R2: A write with word address k places the data in block bytes 4k to 4k+3. Byte 4k is taken from bits [31:24] of the data, and bytes fill the state column by column.
- R3: Start is ignored unless the engine is idle, keys_ready is high and data_stable is high. An ignored start leaves busy low, leaves the round-key index at 0, raises no done pulse and leaves the result unchanged. A start while busy does not disturb the block in progress.
- R4: The round-key index is 0 while idle, so the accepting cycle adds key 0. It is 1 in the first busy cycle and rises by one per cycle up to 10.
- R5: If start is taken at clock edge t, busy is high from edge t to edge t+10. Done is high for exactly one cycle, after edge t+10, and busy is low in that cycle.
- R6: The result equals AES-128 encryption of the loaded block. Rounds 1 to 9 apply SubBytes, ShiftRows (row r rotated left by r bytes), MixColumns and AddRoundKey, in that order. Round 10 omits MixColumns.
- R7: Once done has pulsed, the result words stay unchanged until the next accepted start, including while new plaintext is being written.
- R8: Plaintext words written while a block is being processed do not affect that block. They are used by the next accepted start.
- R9: SubBytes maps each byte to its GF(2^8) inverse modulo x^8+x^4+x^3+x+1, with 0x00 mapped to itself, followed by the standard affine transform with constant 0x63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Plaintext word write enable |
| wr_addr | input | 2 | Plaintext word address (0 = bytes 0..3) |
| wr_data | input | 32 | Plaintext word |
| data_stable | input | 1 | Loaded plaintext is complete |
| keys_ready | input | 1 | Key store has finished expansion |
| start | input | 1 | Begin encryption of the loaded block |
| rk_index | output | 4 | Round-key index requested from the key store |
| rk_data | input | 128 | Round key for rk_index, column 0 in bits [127:96] |
| rd_addr | input | 2 | Result word address |
| rd_data | output | 32 | Result word at rd_addr |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse: ciphertext valid |

## Verification
Start is sampled at edge t. Busy and a round-key index of 1 are therefore due in the cycle that follows t. Each later cycle is due to show the next index, and done is due after edge t+10. The bench drives every input on the falling edge and samples on the falling edge. It counts falling edges from the accepting edge, so each index, busy and done check lands in the exact cycle the requirement names. The result words are combinational from the state register, so they are read in the done cycle and again several cycles later, with the read address settled before each compare.

// File: rtl/aes_pkg.sv
package aes_pkg;

  typedef enum logic { CTRL_IDLE = 1'b0, CTRL_RUN = 1'b1 } ctrl_state_e;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // inverse as a^254 (0 maps to 0), then the affine step
  function automatic logic [7:0] sub_byte_calc(input logic [7:0] a);
    logic [7:0] pw;
    logic [7:0] inv;
    logic [7:0] res;
    pw  = a;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      pw  = gf_mul(pw, pw);
      inv = gf_mul(inv, pw);
    end
    res = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return res;
  endfunction

  function automatic logic [2047:0] sub_table_build();
    logic [2047:0] t;
    t = '0;
    for (int i = 0; i < 256; i++) begin
      t[i*8 +: 8] = sub_byte_calc(8'(i));
    end
    return t;
  endfunction

  localparam logic [2047:0] SUB_TABLE = sub_table_build();

  function automatic logic [31:0] mix_one_col(input logic [31:0] col);
    logic [7:0] a0, a1, a2, a3;
    logic [7:0] d0, d1, d2, d3;
    a0 = col[31:24];
    a1 = col[23:16];
    a2 = col[15:8];
    a3 = col[7:0];
    d0 = gf_dbl(a0);
    d1 = gf_dbl(a1);
    d2 = gf_dbl(a2);
    d3 = gf_dbl(a3);
    return {d0 ^ d1 ^ a1 ^ a2 ^ a3,
            a0 ^ d1 ^ d2 ^ a2 ^ a3,
            a0 ^ a1 ^ d2 ^ d3 ^ a3,
            d0 ^ a0 ^ a1 ^ a2 ^ d3};
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_pkg::*;
(
  input  logic [7:0] byte_in,
  output logic [7:0] byte_out
);

  assign byte_out = SUB_TABLE[{byte_in, 3'b000} +: 8];

endmodule

// File: rtl/aes_sub_shift.sv
module aes_sub_shift #(
  parameter int NUM_COLS = 4,
  parameter int NUM_ROWS = 4,
  localparam int BLOCK_W = 8 * NUM_COLS * NUM_ROWS
) (
  input  logic [BLOCK_W-1:0] blk_in,
  output logic [BLOCK_W-1:0] blk_out
);

  logic [BLOCK_W-1:0] subbed;

  for (genvar n = 0; n < NUM_COLS * NUM_ROWS; n++) begin : g_sbox
    aes_sbox u_sbox (
      .byte_in  (blk_in[BLOCK_W-1-8*n -: 8]),
      .byte_out (subbed[BLOCK_W-1-8*n -: 8])
    );
  end

  // row r of column c takes the byte of column (c + r) mod NUM_COLS
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      localparam int DST = NUM_ROWS * c + r;
      localparam int SRC = NUM_ROWS * ((c + r) % NUM_COLS) + r;
      assign blk_out[BLOCK_W-1-8*DST -: 8] = subbed[BLOCK_W-1-8*SRC -: 8];
    end
  end

endmodule

// File: rtl/aes_mix_columns.sv
module aes_mix_columns
  import aes_pkg::*;
#(
  parameter int NUM_COLS = 4,
  localparam int BLOCK_W = 32 * NUM_COLS
) (
  input  logic [BLOCK_W-1:0] blk_in,
  output logic [BLOCK_W-1:0] blk_out
);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign blk_out[BLOCK_W-1-32*c -: 32] = mix_one_col(blk_in[BLOCK_W-1-32*c -: 32]);
  end

endmodule

// File: rtl/aes_round_ctrl.sv
module aes_round_ctrl
  import aes_pkg::*;
#(
  parameter int NR = 10,
  localparam int IDX_W = $clog2(NR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             keys_ready,
  input  logic             data_stable,
  output logic             accept,
  output logic             round_en,
  output logic             final_round,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] rk_index
);

  ctrl_state_e      st_q;
  logic [IDX_W-1:0] rnd_q;

  assign busy        = (st_q == CTRL_RUN);
  assign accept      = start && !busy && keys_ready && data_stable;
  assign round_en    = busy;
  assign final_round = busy && (rnd_q == IDX_W'(NR));
  assign rk_index    = busy ? rnd_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CTRL_IDLE;
      rnd_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        CTRL_IDLE: begin
          if (accept) begin
            st_q  <= CTRL_RUN;
            rnd_q <= IDX_W'(1);
          end
        end
        CTRL_RUN: begin
          if (rnd_q == IDX_W'(NR)) begin
            st_q  <= CTRL_IDLE;
            rnd_q <= '0;
            done  <= 1'b1;
          end else begin
            rnd_q <= rnd_q + IDX_W'(1);
          end
        end
        default: st_q <= CTRL_IDLE;
      endcase
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r5_last_round_done: assert property (@(posedge clk) disable iff (!rst_n)
    final_round |=> done);

  a_r4_first_index: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rk_index == IDX_W'(1)));

  a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !final_round) |=> (busy && rk_index == $past(rk_index) + IDX_W'(1)));

  a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rk_index <= IDX_W'(NR));

  a_r3_gate_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(keys_ready && data_stable)) |=> !busy);

endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int NR        = 10,
  localparam int BLOCK_W  = WORD_W * NUM_WORDS,
  localparam int ADDR_W   = $clog2(NUM_WORDS),
  localparam int IDX_W    = $clog2(NR + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               data_stable,
  input  logic               keys_ready,
  input  logic               start,
  output logic [IDX_W-1:0]   rk_index,
  input  logic [BLOCK_W-1:0] rk_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_data,
  output logic               busy,
  output logic               done
);

  logic [BLOCK_W-1:0] load_q;
  logic [BLOCK_W-1:0] state_q;
  logic [BLOCK_W-1:0] ss_out;
  logic [BLOCK_W-1:0] mc_out;
  logic [BLOCK_W-1:0] round_val;
  logic               accept;
  logic               round_en;
  logic               final_round;

  aes_round_ctrl #(.NR(NR)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .keys_ready  (keys_ready),
    .data_stable (data_stable),
    .accept      (accept),
    .round_en    (round_en),
    .final_round (final_round),
    .busy        (busy),
    .done        (done),
    .rk_index    (rk_index)
  );

  aes_sub_shift #(.NUM_COLS(NUM_WORDS), .NUM_ROWS(WORD_W / 8)) u_sub_shift (
    .blk_in  (state_q),
    .blk_out (ss_out)
  );

  aes_mix_columns #(.NUM_COLS(NUM_WORDS)) u_mix (
    .blk_in  (ss_out),
    .blk_out (mc_out)
  );

  assign round_val = final_round ? ss_out : mc_out;

  // plaintext staging, word 0 at the top of the block
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (wr_en) begin
      load_q[BLOCK_W-1-WORD_W*wr_addr -: WORD_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (accept) begin
      state_q <= load_q ^ rk_data;
    end else if (round_en) begin
      state_q <= round_val ^ rk_data;
    end
  end

  assign rd_data = state_q[BLOCK_W-1-WORD_W*rd_addr -: WORD_W];

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(state_q));

  a_r8_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(load_q));

  a_r3_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !accept);

endmodule

// File: tb/tb_aes128_iter_enc.sv
module tb_aes128_iter_enc;

  localparam int CLK_PERIOD = 10;

  // {key, plaintext, ciphertext}
  localparam logic [383:0] VEC [3] = '{
    {128'h000102030405060708090a0b0c0d0e0f,
     128'h00112233445566778899aabbccddeeff,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c,
     128'h3243f6a8885a308d313198a2e0370734,
     128'h3925841d02dc09fbdc118597196a0b32},
    {128'h00000000000000000000000000000000,
     128'h00000000000000000000000000000000,
     128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         data_stable = 1'b0;
  logic         keys_ready = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   rk_index;
  logic [127:0] rk_data;
  logic [1:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         busy;
  logic         done;

  logic [127:0] rk_mem [0:10];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign rk_data = (rk_index <= 4'd10) ? rk_mem[rk_index] : '0;

  aes128_iter_enc dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .data_stable(data_stable), .keys_ready(keys_ready), .start(start),
    .rk_index(rk_index), .rk_data(rk_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_sub(input logic [7:0] a);
    logic [7:0] inv = 0;
    logic [7:0] o;
    for (int j = 1; j < 256; j++) if (ref_mul(a, 8'(j)) == 8'h01) inv = 8'(j);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return o ^ 8'h63;
  endfunction

  task automatic expand_key(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {ref_sub(t[31:24]) ^ rc, ref_sub(t[23:16]), ref_sub(t[15:8]), ref_sub(t[7:0])};
        rc = rc[7] ? ((rc << 1) ^ 8'h1b) : (rc << 1);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk_mem[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_block(input logic [127:0] pt);
    for (int k = 0; k < 4; k++) write_word(2'(k), pt[127-32*k -: 32]);
  endtask

  task automatic read_result(output logic [127:0] res);
    for (int k = 0; k < 4; k++) begin
      rd_addr = 2'(k);
      #1;
      res[127-32*k -: 32] = rd_data;
    end
  endtask

  // mode 0 plain, 1 start pulses while busy, 2 write next_pt while busy
  task automatic run_block(input logic [127:0] exp_ct, input int mode,
                           input logic [127:0] next_pt, input string tag);
    logic [127:0] res;
    data_stable = 1'b1;
    keys_ready  = 1'b1;
    @(negedge clk);
    chk({tag, " R4 idle index 0"}, 128'(rk_index), 128'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R5 busy after accept"}, 128'(busy), 128'd1);
    chk({tag, " R4 first round index"}, 128'(rk_index), 128'd1);
    for (int k = 2; k <= 10; k++) begin
      if (mode == 2 && k <= 5) begin
        wr_en = 1'b1; wr_addr = 2'(k-2); wr_data = next_pt[127-32*(k-2) -: 32];
      end else begin
        wr_en = 1'b0;
      end
      if (mode == 1) start = (k == 4 || k == 5);
      @(negedge clk);
      chk({tag, " R4 index step"}, 128'(rk_index), 128'(k));
      chk({tag, " R5 no early done"}, 128'({busy, done}), 128'd2);
    end
    wr_en = 1'b0;
    start = 1'b0;
    @(negedge clk);
    chk({tag, " R5 done pulse, busy low"}, 128'({busy, done}), 128'd1);
    read_result(res);
    chk({tag, " R6 ciphertext"}, res, exp_ct);
    @(negedge clk);
    chk({tag, " R5 done one cycle"}, 128'({busy, done}), 128'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] res;
    logic [127:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_result(res);
    chk("R1 reset result", res, 128'd0);
    chk("R1 reset flags", 128'({busy, done, rk_index}), 128'd0);

    // vector table walk (R2, R6, R9)
    for (int i = 0; i < 3; i++) begin
      expand_key(VEC[i][383:256]);
      load_block(VEC[i][255:128]);
      run_block(VEC[i][127:0], 0, '0, $sformatf("vec%0d", i));
    end

    // R3: start ignored without keys_ready / data_stable
    read_result(held);
    keys_ready = 1'b0; data_stable = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3 no keys: idle", 128'({busy, done, rk_index}), 128'd0);
    keys_ready = 1'b1; data_stable = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3 not stable: idle", 128'({busy, done, rk_index}), 128'd0);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R3 ignored start: no done", 128'({busy, done}), 128'd0);
    end
    read_result(res);
    chk("R3 ignored start: result kept", res, held);

    // R3: start pulses while busy
    expand_key(VEC[1][383:256]);
    load_block(VEC[1][255:128]);
    run_block(VEC[1][127:0], 1, '0, "busy-start R3");
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R3 busy start: no second run", 128'({busy, done}), 128'd0);
    end

    // R8: next plaintext written during a block
    expand_key(VEC[0][383:256]);
    load_block(VEC[0][255:128]);
    run_block(VEC[0][127:0], 2, VEC[2][255:128], "overlap R8");
    expand_key(VEC[2][383:256]);
    run_block(VEC[2][127:0], 0, '0, "next R8");

    // R7: result held while new words arrive
    load_block(128'hdeadbeef_01234567_89abcdef_f0e1d2c3);
    repeat (4) @(negedge clk);
    read_result(res);
    chk("R7 result held after writes", res, VEC[2][127:0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule